// File: doc/BRIEF.md
# Four-Bit-Coded Integer ALU

A purely combinational integer arithmetic and logic unit for a simple load/store datapath. A 4-bit operation code selects one of six functions on two operand words. The block returns the selected word together with a flag that is high whenever that word is all zeros. The decode stage supplies the operation code. The datapath uses the flag to decide equality branches: it subtracts the two register values and ANDs the flag with its branch enable.

Codes outside the six listed ones are not errors. They yield a zero word, so the outputs are always defined. The block has no clock and no state: both outputs follow the inputs within the same cycle.

Top module: `int_alu4`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of the two operands.
- R2: Code 4'b0001 returns the bitwise OR of the two operands.
- R3: Code 4'b0010 returns the sum of the operands modulo 2^32, with no trap and no carry output.
- R4: Code 4'b0110 returns operand A minus operand B modulo 2^32.
- R5: Code 4'b0111 compares the operands as signed two's-complement numbers and returns 32'd1 when A < B, else 32'd0.
- R6: Code 4'b1100 returns the bitwise NOR of the two operands.
- R7: Every other code (the ten values not listed in R1 to R6) returns 32'd0.
- R8: The zero flag is 1 exactly when the result word is all zeros, for every code, including the unlisted codes of R7.
- R9: With code 4'b0110, the zero flag is 1 when the operands are equal and 0 when they differ, so it can drive an equality branch.
- R10: Both outputs depend only on the present inputs. A given input set always gives the same outputs, whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select (encodings in R1 to R7) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; the subtrahend, and the right-hand side of the comparison |
| result | output | 32 | Selected result word |
| is_zero | output | 1 | High when result is all zeros |

## Verification
The block holds no internal state. A fault in the adder's carry chain, the comparison sign logic or the selection decode shows at the result port in the same cycle as the input that triggers it. A fault in the chunked zero detector shows as a disagreement between is_zero and the result word, also in the same cycle. Some faults depend on the operands, such as a missed borrow into the top bit or wrong signed handling when the signs differ. These faults only show for the operand values that expose them, so the stimulus mixes boundary words with random words across all sixteen codes.

// File: rtl/int_alu4_pkg.sv
package int_alu4_pkg;

  localparam int unsigned OP_BITS = 4;

  typedef enum logic [OP_BITS-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  // True for the six codes that select a defined function.
  function automatic logic op_is_listed(input logic [OP_BITS-1:0] code);
    case (code)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: op_is_listed = 1'b1;
      default:                                       op_is_listed = 1'b0;
    endcase
  endfunction

  // The adder subtracts for SUB and SLT.
  function automatic logic op_needs_sub(input logic [OP_BITS-1:0] code);
    op_needs_sub = (code == OP_SUB) || (code == OP_SLT);
  endfunction

endpackage

// File: rtl/int_alu4_bitwise.sv
module int_alu4_bitwise #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] and_word,
  output logic [WIDTH-1:0] or_word,
  output logic [WIDTH-1:0] nor_word
);

  for (genvar bit_i = 0; bit_i < WIDTH; bit_i++) begin : g_bit
    logic any_set;
    assign any_set            = lhs[bit_i] | rhs[bit_i];
    assign and_word[bit_i]    = lhs[bit_i] & rhs[bit_i];
    assign or_word[bit_i]     = any_set;
    assign nor_word[bit_i]    = ~any_set;
  end

  // The NOR path is built from the OR term and must stay its complement. R6
  always_comb begin
    p_nor_complement_r6: assert ((nor_word ^ or_word) == {WIDTH{1'b1}})
      else $error("NOR word is not the complement of OR word");
  end

endmodule

// File: rtl/int_alu4_arith.sv
module int_alu4_arith #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum_word,
  output logic             signed_less
);

  localparam int unsigned MSB = WIDTH - 1;

  // One adder serves add and subtract: lhs + ~rhs + 1 when subtracting.
  function automatic logic [WIDTH-1:0] add_or_sub(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             sub
  );
    logic [WIDTH-1:0] y_eff;
    y_eff      = sub ? ~y : y;
    add_or_sub = x + y_eff + {{(WIDTH-1){1'b0}}, sub};
  endfunction

  // Signed less-than from the difference: the operand sign decides when
  // the signs differ, otherwise the sign of the difference decides.
  function automatic logic lt_from_diff(
    input logic x_sign,
    input logic y_sign,
    input logic diff_sign
  );
    lt_from_diff = (x_sign ^ y_sign) ? x_sign : diff_sign;
  endfunction

  logic sign_differs;
  logic diff_sign;

  assign sum_word     = add_or_sub(lhs, rhs, do_sub);
  assign sign_differs = lhs[MSB] ^ rhs[MSB];
  assign diff_sign    = sum_word[MSB];
  assign signed_less  = lt_from_diff(lhs[MSB], rhs[MSB], diff_sign);

  always_comb begin
    // Subtract result plus subtrahend must give back the minuend. R4
    p_sub_inverts_add_r4: assert (!do_sub || ((sum_word + rhs) == lhs))
      else $error("difference plus subtrahend does not recover minuend");
    // With mixed signs the negative operand is the smaller one. R5
    p_mixed_sign_lt_r5: assert (!(do_sub && sign_differs) || (signed_less == lhs[MSB]))
      else $error("mixed-sign comparison wrong");
  end

endmodule

// File: rtl/int_alu4_zero.sv
module int_alu4_zero #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic [WIDTH-1:0] word,
  output logic             all_zero
);

  localparam int unsigned N_CHUNKS = (WIDTH + CHUNK - 1) / CHUNK;
  localparam int unsigned PAD_W    = N_CHUNKS * CHUNK;

  logic [PAD_W-1:0]    padded;
  logic [N_CHUNKS-1:0] chunk_busy;

  always_comb begin
    padded            = '0;
    padded[WIDTH-1:0] = word;
  end

  for (genvar c = 0; c < N_CHUNKS; c++) begin : g_chunk
    assign chunk_busy[c] = |padded[c*CHUNK +: CHUNK];
  end

  assign all_zero = ~|chunk_busy;

  // A single set bit must mark exactly one chunk busy. R8
  always_comb begin
    p_single_bit_chunk_r8: assert (($countones(word) != 1) || ($countones(chunk_busy) == 1))
      else $error("one set bit did not mark exactly one chunk");
  end

endmodule

// File: rtl/int_alu4.sv
module int_alu4
  import int_alu4_pkg::*;
#(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned ZERO_CHUNK = 8
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             is_zero
);

  logic [WIDTH-1:0] and_word;
  logic [WIDTH-1:0] or_word;
  logic [WIDTH-1:0] nor_word;
  logic [WIDTH-1:0] sum_word;
  logic             signed_less;
  logic             use_sub;
  logic             code_listed;

  assign use_sub     = op_needs_sub(op_code);
  assign code_listed = op_is_listed(op_code);

  int_alu4_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .lhs      (opnd_a),
    .rhs      (opnd_b),
    .and_word (and_word),
    .or_word  (or_word),
    .nor_word (nor_word)
  );

  int_alu4_arith #(.WIDTH(WIDTH)) u_arith (
    .lhs         (opnd_a),
    .rhs         (opnd_b),
    .do_sub      (use_sub),
    .sum_word    (sum_word),
    .signed_less (signed_less)
  );

  always_comb begin
    case (op_code)
      OP_AND:  result = and_word;
      OP_OR:   result = or_word;
      OP_ADD:  result = sum_word;
      OP_SUB:  result = sum_word;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, signed_less};
      OP_NOR:  result = nor_word;
      default: result = '0;
    endcase
  end

  int_alu4_zero #(.WIDTH(WIDTH), .CHUNK(ZERO_CHUNK)) u_zero (
    .word     (result),
    .all_zero (is_zero)
  );

  always_comb begin
    p_unlisted_gives_zero_r7: assert (code_listed || (result == '0 && is_zero))
      else $error("unlisted code produced a non-zero word");
    p_slt_is_boolean_r5: assert ((op_code != OP_SLT) || (result[WIDTH-1:1] == '0))
      else $error("comparison result has upper bits set");
    p_flag_tracks_word_r8: assert (is_zero == (result == '0))
      else $error("zero flag disagrees with result");
    p_equal_sub_zero_r9: assert ((op_code != OP_SUB) || (is_zero == (opnd_a == opnd_b)))
      else $error("subtract zero flag does not reflect equality");
  end

endmodule

// File: tb/tb_int_alu4.sv
module tb_int_alu4;

  logic        clk = 1'b0;
  logic [3:0]  op_code = 4'b0000;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic        is_zero;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  int_alu4 dut (
    .op_code (op_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .result  (result),
    .is_zero (is_zero)
  );

  // Behavioural reference written from the requirements.
  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    longint unsigned wide;
    case (c)
      4'b0000: return a & b;                                    // R1
      4'b0001: return a | b;                                    // R2
      4'b0010: begin wide = longint'(a) + longint'(b);           // R3
                     return wide[31:0]; end
      4'b0110: begin wide = (64'd1 << 32) + longint'(a) - longint'(b); // R4
                     return wide[31:0]; end
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; // R5
      4'b1100: return ~(a | b);                                 // R6
      default: return 32'd0;                                    // R7
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] exp_w;
    logic        exp_z;
    @(posedge clk);
    #1;
    op_code = c; opnd_a = a; opnd_b = b;
    exp_w = model(c, a, b);
    exp_z = (exp_w == 32'd0);                                   // R8
    @(negedge clk);
    n_cmp++;
    if (result !== exp_w) begin
      n_bad++;
      $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h", tag, c, a, b, result, exp_w);
    end
    n_cmp++;
    if (is_zero !== exp_z) begin
      n_bad++;
      $display("FAIL R8 flag (%s) op=%b a=%h b=%h actual=%b expected=%b", tag, c, a, b, is_zero, exp_z);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    // All-zero inputs as the quiescent state: AND of zeros, flag high.
    apply(4'b0000, 32'h0, 32'h0, "R1");
    apply(4'b0000, 32'hF0F0_1234, 32'h0FF0_FFFF, "R1");
    apply(4'b0001, 32'h8000_0000, 32'h0000_0001, "R2");
    apply(4'b0001, 32'h0, 32'h0, "R2");
    // R3 wrap-around to zero sets the flag.
    apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, "R3");
    apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, "R3");
    // R4 borrow wrap, R9 equality and inequality.
    apply(4'b0110, 32'h0, 32'h1, "R4");
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R9");
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEE, "R9");
    apply(4'b0110, 32'h8000_0000, 32'h0000_0000, "R9");
    // R5 signed boundaries.
    apply(4'b0111, 32'h8000_0000, 32'h0000_0001, "R5");
    apply(4'b0111, 32'h0000_0001, 32'h8000_0000, "R5");
    apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5");
    apply(4'b0111, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R5");
    apply(4'b0111, 32'h0000_0005, 32'h0000_0005, "R5");
    apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
    // R6 NOR of zeros is all ones, of all ones is zero.
    apply(4'b1100, 32'h0, 32'h0, "R6");
    apply(4'b1100, 32'hFFFF_0000, 32'h0000_FFFF, "R6");
    // R7 every unlisted code with busy operands.
    for (int c = 0; c < 16; c++) begin
      apply(4'(c), 32'hFFFF_FFFF, 32'h1234_5678, tag_of(4'(c)));
    end
    // R10 same inputs after different histories give the same outputs.
    apply(4'b0010, 32'h1111_1111, 32'h2222_2222, "R10");
    apply(4'b1100, 32'h0, 32'h0, "R10");
    apply(4'b0010, 32'h1111_1111, 32'h2222_2222, "R10");
    // Random sweep over all codes.
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  rc;
      logic [31:0] ra;
      logic [31:0] rb;
      rc = 4'($urandom_range(0, 15));
      ra = $urandom;
      rb = (i % 5 == 0) ? ra : $urandom;
      apply(rc, ra, rb, tag_of(rc));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule